// File: doc/BRIEF.md
# Pausable DRAM Refresh Row Sequencer

This block sits on the DRAM side of the command path. It turns each refresh command into a short series of per-row refresh cycles. A refresh command covers a bundle of consecutive rows, and the bundle holds 1, 2, 4 or 8 rows. Each row gets one activate/precharge cycle of fixed length, counted in clock cycles. The sequencer presents the row address and pulses a strobe when that row's cycle begins.

The refresh-enable input is sampled active-low as a pause request. When it drops, the row already in progress still finishes. No further row starts, and the row address counter keeps its value. When the enable returns, the sequencer refreshes only the rows of the bundle that remain, starting at the held address. A read that pauses refresh therefore waits at most one row cycle, not a whole bundle.

Signalling runs one way: the controller drives command and enable, and the block returns no acknowledgement. The controller sees the busy flag and the bundle-done flag.

Top module: `refresh_row_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), busy, row_act and bundle_done are 0 and row_addr is 0.
- R2: When ref_cmd and ref_en are both high at a clock edge with no bundle open, the first row starts at that edge. From that edge, busy and row_act are 1 and row_addr shows the first row of the bundle.
- R3: Each row keeps busy high for exactly ROW_CYCLES cycles. row_act is high only in the first cycle of each row. While ref_en stays high, the next row of the bundle follows with no idle cycle between rows.
- R4: After each completed row, row_addr advances by one. A bundle refreshes ROWS_PER_BUNDLE consecutive addresses.
- R5: bundle_done is high for exactly one cycle, the first cycle after the last row of the bundle completes. busy is 0 in that cycle.
- R6: While ref_en is low, a row already in progress completes in full. No new row starts, and row_addr holds its value.
- R7: When ref_en returns high with rows of the bundle still outstanding, the next row starts at the held address. Only the remaining rows are refreshed, and then bundle_done pulses.
- R8: After ref_en drops, busy remains high for at most ROW_CYCLES cycles.
- R9: row_addr wraps from TOTAL_ROWS-1 to 0.
- R10: A ref_cmd that arrives while a bundle is open has no effect. No extra rows follow the bundle's completion.
- R11: A ref_cmd that arrives while ref_en is low opens the bundle without starting a row. The first row starts at the first edge at which ref_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_cmd | input | 1 | Refresh command: opens a bundle when none is open |
| ref_en | input | 1 | Refresh enable; low requests a pause at the next row boundary |
| row_addr | output | $clog2(TOTAL_ROWS) | Address of the row being refreshed, or of the next row to refresh |
| row_act | output | 1 | One-cycle strobe at the start of each row's activate/precharge cycle |
| busy | output | 1 | High while a row cycle is in progress |
| bundle_done | output | 1 | One-cycle pulse after the last row of a bundle completes |

## Verification
The bench builds the sequencer with ROWS_PER_BUNDLE=4, ROW_CYCLES=5 and TOTAL_ROWS=10. A four-row bundle leaves room to pause after the first row and resume with three rows left. A five-cycle row makes the pause window and the row strobe spacing distinct from one cycle. Because the total of ten rows is not a power of two, the third bundle runs through the wrap from 9 to 0, and a mis-sized counter would not hide it.

// File: rtl/refresh_seq_pkg.sv
// Package: shared helpers and types for the refresh row sequencer.
// Assumes: callers pass positive counts to width helpers.
package refresh_seq_pkg;

    // Width of a counter that holds values 0..n-1, never less than one bit.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // State of the per-row timer.
    typedef enum logic {
        ROW_IDLE   = 1'b0,
        ROW_ACTIVE = 1'b1
    } row_phase_e;

endpackage

// File: rtl/refresh_row_timer.sv
// Module: refresh_row_timer
// Times one activate/precharge cycle of ROW_CYCLES clocks per row.
// A start in the final cycle of a row chains the next row with no gap.
// Assumes: start_row is only raised when the caller wants a new row.
module refresh_row_timer
    import refresh_seq_pkg::*;
#(
    parameter int ROW_CYCLES = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_row,
    output logic busy,
    output logic row_last
);
    localparam int CNT_W = cnt_width(ROW_CYCLES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ROW_CYCLES - 1);

    row_phase_e       phase;
    logic [CNT_W-1:0] cyc_cnt;

    // Phase and cycle counter: restart on a start, idle after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= ROW_IDLE;
            cyc_cnt <= '0;
        end else if (start_row) begin
            phase   <= ROW_ACTIVE;
            cyc_cnt <= '0;
        end else if (row_last) begin
            phase   <= ROW_IDLE;
            cyc_cnt <= '0;
        end else if (phase == ROW_ACTIVE) begin
            cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    // Outputs decoded from phase and count.
    always_comb begin
        busy     = (phase == ROW_ACTIVE);
        row_last = busy && (cyc_cnt == LAST_CNT);
    end
endmodule

// File: rtl/refresh_bundle_tracker.sv
// Module: refresh_bundle_tracker
// Tracks whether a bundle is open and how many of its rows are complete.
// It reports whether further rows are owed and pulses done after the last row.
// Assumes: row_last is high for exactly one cycle per completed row.
module refresh_bundle_tracker
    import refresh_seq_pkg::*;
#(
    parameter int ROWS_PER_BUNDLE = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_cmd,
    input  logic row_last,
    output logic rows_pending,
    output logic bundle_done
);
    localparam int IDX_W = cnt_width(ROWS_PER_BUNDLE);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROWS_PER_BUNDLE - 1);

    logic             open_q;
    logic [IDX_W-1:0] row_idx;
    logic             accept;
    logic             final_row;

    // Command acceptance and final-row decode.
    always_comb begin
        accept       = ref_cmd && !open_q;
        final_row    = row_last && (row_idx == LAST_IDX);
        rows_pending = (open_q && !final_row) || accept;
    end

    // Bundle state: open on accept, count rows, close and pulse at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q      <= 1'b0;
            row_idx     <= '0;
            bundle_done <= 1'b0;
        end else begin
            bundle_done <= 1'b0;
            if (accept) begin
                open_q <= 1'b1;
            end
            if (final_row) begin
                open_q      <= 1'b0;
                row_idx     <= '0;
                bundle_done <= 1'b1;
            end else if (row_last) begin
                row_idx <= row_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/refresh_addr_counter.sv
// Module: refresh_addr_counter
// Holds the global refresh row address. It advances only when a row
// completes, so a paused sequencer leaves it frozen. Wraps at TOTAL_ROWS.
// Assumes: TOTAL_ROWS >= 2.
module refresh_addr_counter
    import refresh_seq_pkg::*;
#(
    parameter int TOTAL_ROWS = 65536
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              advance,
    output logic [cnt_width(TOTAL_ROWS)-1:0]  addr
);
    localparam int ADDR_W = cnt_width(TOTAL_ROWS);
    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(TOTAL_ROWS - 1);

    // Gated incrementer with wrap at the last row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (advance) begin
            addr <= (addr == TOP_ADDR) ? '0 : addr + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_row_seq.sv
// Module: refresh_row_seq (top)
// Refreshes a bundle of rows per refresh command, one row at a time.
// Refresh enable low pauses at the next row boundary. The bundle resumes at
// the held address once enable returns. Nothing is sent back to the controller
// beyond the status outputs.
// Assumes: ROWS_PER_BUNDLE in {1,2,4,8}, ROW_CYCLES >= 1, TOTAL_ROWS >= 2.
module refresh_row_seq
    import refresh_seq_pkg::*;
#(
    parameter int ROWS_PER_BUNDLE = 8,
    parameter int ROW_CYCLES      = 12,
    parameter int TOTAL_ROWS      = 65536
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             ref_cmd,
    input  logic                             ref_en,
    output logic [cnt_width(TOTAL_ROWS)-1:0] row_addr,
    output logic                             row_act,
    output logic                             busy,
    output logic                             bundle_done
);
    logic rows_pending;
    logic row_last;
    logic start_row;

    // Row start: enabled, rows owed, and the timer free or finishing this cycle.
    always_comb begin
        start_row = ref_en && rows_pending && (!busy || row_last);
    end

    // Activate strobe registered so it lines up with the first busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_act <= 1'b0;
        end else begin
            row_act <= start_row;
        end
    end

    refresh_row_timer #(
        .ROW_CYCLES(ROW_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_row(start_row),
        .busy     (busy),
        .row_last (row_last)
    );

    refresh_bundle_tracker #(
        .ROWS_PER_BUNDLE(ROWS_PER_BUNDLE)
    ) u_bundle (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_cmd     (ref_cmd),
        .row_last    (row_last),
        .rows_pending(rows_pending),
        .bundle_done (bundle_done)
    );

    refresh_addr_counter #(
        .TOTAL_ROWS(TOTAL_ROWS)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(row_last),
        .addr   (row_addr)
    );
endmodule

// File: rtl/refresh_row_seq_checker.sv
// Module: refresh_row_seq_checker
// Temporal properties of the sequencer's ports, attached with bind.
// Assumes: same parameter values as the bound instance.
module refresh_row_seq_checker
    import refresh_seq_pkg::*;
#(
    parameter int ROW_CYCLES = 12,
    parameter int TOTAL_ROWS = 65536
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             ref_en,
    input logic [cnt_width(TOTAL_ROWS)-1:0] row_addr,
    input logic                             row_act,
    input logic                             busy,
    input logic                             bundle_done
);
    int pause_run;

    // Count consecutive busy cycles spent with refresh enable low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_run <= 0;
        end else if (!ref_en && busy) begin
            pause_run <= pause_run + 1;
        end else begin
            pause_run <= 0;
        end
    end

    assert_act_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
        row_act |-> busy);

    assert_act_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_act && ROW_CYCLES > 1) |=> !row_act);

    assert_addr_held_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(row_addr));

    assert_done_after_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bundle_done) |-> ($past(busy) && !busy));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bundle_done |=> !bundle_done);

    assert_pause_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pause_run <= ROW_CYCLES);

    // Address stays inside the row space.
    always @(posedge clk) begin
        if (rst_n) begin
            assert_addr_range_R9: assert (int'(row_addr) < TOTAL_ROWS);
        end
    end
endmodule

bind refresh_row_seq refresh_row_seq_checker #(
    .ROW_CYCLES(ROW_CYCLES),
    .TOTAL_ROWS(TOTAL_ROWS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_en     (ref_en),
    .row_addr   (row_addr),
    .row_act    (row_act),
    .busy       (busy),
    .bundle_done(bundle_done)
);

// File: tb/tb_refresh_row_seq.sv
// Directed bench for refresh_row_seq: one task per scenario.
module tb_refresh_row_seq;
    localparam int RPB = 4;
    localparam int RC  = 5;
    localparam int TOT = 10;
    localparam int AW  = $clog2(TOT);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_cmd = 1'b0;
    logic          ref_en = 1'b0;
    logic [AW-1:0] row_addr;
    logic          row_act;
    logic          busy;
    logic          bundle_done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    refresh_row_seq #(
        .ROWS_PER_BUNDLE(RPB),
        .ROW_CYCLES     (RC),
        .TOTAL_ROWS     (TOT)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_cmd    (ref_cmd),
        .ref_en     (ref_en),
        .row_addr   (row_addr),
        .row_act    (row_act),
        .busy       (busy),
        .bundle_done(bundle_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Check rows from the one just started (current sample) through bundle_done.
    // inject_at >= 0 pulses ref_cmd for one cycle after that sample (R10).
    task automatic run_rows(input string req, input int base, input int nrows, input int inject_at);
        for (int k = 0; k <= nrows * RC; k++) begin
            if (k < nrows * RC) begin
                chk(req, "busy in row (R3)", int'(busy), 1);
                chk(req, "row_act strobe (R3)", int'(row_act), (k % RC == 0) ? 1 : 0);
                chk(req, "row_addr (R4/R9)", int'(row_addr), (base + k / RC) % TOT);
                chk(req, "no early done (R5)", int'(bundle_done), 0);
            end else begin
                chk(req, "busy after bundle (R5)", int'(busy), 0);
                chk(req, "bundle_done pulse (R5)", int'(bundle_done), 1);
                chk(req, "addr after bundle (R4/R9)", int'(row_addr), (base + nrows) % TOT);
            end
            ref_cmd = (k == inject_at);
            step();
        end
        ref_cmd = 1'b0;
        chk(req, "bundle_done one cycle (R5)", int'(bundle_done), 0);
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "row_act", int'(row_act), 0);
        chk("R1", "bundle_done", int'(bundle_done), 0);
        chk("R1", "row_addr", int'(row_addr), 0);
    endtask

    // R2, R3, R4, R5: full uninterrupted bundle.
    task automatic t_full_bundle(input int base);
        ref_cmd = 1'b1;
        ref_en  = 1'b1;
        step();
        ref_cmd = 1'b0;
        chk("R2", "start busy", int'(busy), 1);
        chk("R2", "start strobe", int'(row_act), 1);
        chk("R2", "start addr", int'(row_addr), base);
        run_rows("R2", base, RPB, -1);
    endtask

    // R6, R7, R8: pause after first row starts, resume later.
    task automatic t_pause_resume(input int base);
        int busy_while_low;
        busy_while_low = 0;
        ref_cmd = 1'b1;
        ref_en  = 1'b1;
        step();
        ref_cmd = 1'b0;
        chk("R6", "row started", int'(busy), 1);
        ref_en = 1'b0;
        step();
        for (int k = 1; k < RC; k++) begin
            chk("R6", "row in progress completes", int'(busy), 1);
            chk("R6", "no strobe mid-row", int'(row_act), 0);
            busy_while_low++;
            step();
        end
        chk("R8", "busy cleared within one row", int'(busy_while_low <= RC), 1);
        for (int k = 0; k < 10; k++) begin
            chk("R6", "no new row while paused", int'(busy), 0);
            chk("R6", "no strobe while paused", int'(row_act), 0);
            chk("R6", "address held", int'(row_addr), (base + 1) % TOT);
            chk("R6", "no done while paused", int'(bundle_done), 0);
            step();
        end
        ref_en = 1'b1;
        step();
        chk("R7", "resume strobe", int'(row_act), 1);
        chk("R7", "resume at held addr", int'(row_addr), (base + 1) % TOT);
        run_rows("R7", base + 1, RPB - 1, -1);
    endtask

    // R9, R10: bundle across the wrap, with a stray command mid-bundle.
    task automatic t_wrap_and_stray(input int base);
        ref_cmd = 1'b1;
        ref_en  = 1'b1;
        step();
        ref_cmd = 1'b0;
        run_rows("R9", base, RPB, 7);
        for (int k = 0; k < 2 * RC; k++) begin
            step();
            chk("R10", "stray command added no row", int'(busy), 0);
            chk("R10", "address unchanged", int'(row_addr), (base + RPB) % TOT);
        end
    endtask

    // R11: command while disabled is remembered until enable.
    task automatic t_cmd_while_disabled(input int base);
        ref_en  = 1'b0;
        ref_cmd = 1'b1;
        step();
        ref_cmd = 1'b0;
        for (int k = 0; k < 6; k++) begin
            chk("R11", "no row while disabled", int'(busy), 0);
            step();
        end
        ref_en = 1'b1;
        step();
        chk("R11", "row starts on enable", int'(row_act), 1);
        run_rows("R11", base, RPB, -1);
    endtask

    initial begin
        t_reset();
        t_full_bundle(0);
        t_pause_resume(4);
        t_wrap_and_stray(8);
        t_cmd_while_disabled(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule